// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block controls how CPU memory accesses to the legacy window from 768 KB up to 1 MB are steered. Seven byte-wide attribute registers sit behind a simple configuration port. Each register holds two 4-bit fields, and each field governs one address region. For every access presented on the 32-bit memory address input, the block reports two things at once: whether a read at that address should be served by shadow DRAM, and whether a write should update shadow DRAM. When a select is low, that direction goes to the ROM/PCI side instead.

Because reads and writes are decided separately, software can copy firmware into DRAM while still running from ROM. It does this by enabling writes with reads disabled, and it can later switch the region to DRAM-only reads. Addresses outside the window always go to DRAM in both directions. Address decode is purely combinational. Register updates are clocked, so they apply to the access presented on the cycle after the write.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, all seven attribute registers (configuration offsets 0x59 to 0x5F) read back 0x00.
- R2: A configuration write to offsets 0x59 to 0x5F stores the whole byte, unused bits included, and a later read of that offset returns it. Other offsets read 0x00, and writes to them change no attribute register or select output.
- R3: Region i is governed by the register at offset 0x59 + i/2. Even i uses bits 3:0 and odd i uses bits 7:4.
- R4: Within a region's field, bit 0 is read-enable. When it is set, a read at an address in the region selects DRAM (dram_rd_sel_o = 1). When it is clear, dram_rd_sel_o = 0 (ROM/PCI).
- R5: Within a region's field, bit 1 is write-enable. When it is set, dram_wr_sel_o = 1, and when it is clear, dram_wr_sel_o = 0. Field bits 2 and 3 affect neither select.
- R6: Region 0 (bits 3:0 of offset 0x59) is reserved. Its value affects no access.
- R7: Region 1 is 0xF0000 to 0xFFFFF. Regions 2 to 9 are the consecutive 16 KB blocks from 0xC0000 to 0xDFFFF, in ascending order. Regions 10 to 13 are the 16 KB blocks from 0xE0000 to 0xEFFFF, in ascending order.
- R8: Any address below 0xC0000, or at or above 0x100000 (including addresses whose low 20 bits fall in the window), drives both selects to 1.
- R9: A register write applies to accesses from the cycle after the write edge. Before that edge, the old value still governs.
- R10: Read and write routing are independent, so either select may be 1 while the other is 0 for the same access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_addr_i |
| mem_addr_i | input | 32 | CPU memory access address |
| dram_rd_sel_o | output | 1 | Read at mem_addr_i is served by DRAM |
| dram_wr_sel_o | output | 1 | Write at mem_addr_i updates DRAM |

## Verification
The assertions assume that the configuration address and the memory address are stable and free of X while reset is released. They also assume that a read-back comparison is made only when the configuration offset is held for the cycle after a write. The bench drives all inputs on the falling edge and holds them between edges, which satisfies these assumptions. It mixes random attribute writes, including writes to offsets just outside the attribute range, with random addresses drawn from inside the window, below it and above 1 MB. Directed probes cover every region boundary, the reserved field, the unused field bits and the one-cycle update timing.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_REGS  = 7;
  localparam int unsigned NIB_W     = REG_W / 2;
  localparam int unsigned NUM_RGN   = 2 * NUM_REGS;
  localparam int unsigned RGN_W     = $clog2(NUM_RGN);
  localparam logic [7:0]  CFG_BASE  = 8'h59;
  localparam int unsigned RD_EN_BIT = 0;
  localparam int unsigned WR_EN_BIT = 1;

  typedef logic [RGN_W-1:0] rgn_idx_t;
endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
  import shadow_attr_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [7:0]                addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic [NUM_REGS*REG_W-1:0] attr_o
);
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] OFF = CFG_BASE + 8'(g);
    logic [REG_W-1:0] q;
    assign hit[g] = (addr_i == OFF);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              q <= '0;
      else if (we_i && hit[g])  q <= wdata_i;
    end
    assign attr_o[g*REG_W +: REG_W] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (hit[k]) rdata_o = attr_o[k*REG_W +: REG_W];
  end
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_attr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output rgn_idx_t          idx_o
);
  logic below_1m;
  assign below_1m = (addr_i[ADDR_W-1:20] == '0);

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    if (below_1m && addr_i[19:18] == 2'b11) begin
      hit_o = 1'b1;
      // 0xF0000-0xFFFFF is one 64 KB region, the rest are 16 KB blocks from 0xC0000
      if (addr_i[19:16] == 4'hF) idx_o = rgn_idx_t'(1);
      else                       idx_o = rgn_idx_t'(2) + rgn_idx_t'(addr_i[17:14]);
    end
  end
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_attr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              dram_rd_sel_o,
  output logic              dram_wr_sel_o
);
  logic [NUM_REGS*REG_W-1:0] attr;
  logic                      rgn_hit;
  rgn_idx_t                  rgn_idx;
  logic [NIB_W-1:0]          nib;

  shadow_attr_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .attr_o  (attr)
  );

  shadow_region_decode u_dec (
    .addr_i (mem_addr_i),
    .hit_o  (rgn_hit),
    .idx_o  (rgn_idx)
  );

  // region i field sits at bit i*NIB_W of the packed register bank
  assign nib = attr[rgn_idx*NIB_W +: NIB_W];

  assign dram_rd_sel_o = rgn_hit ? nib[RD_EN_BIT] : 1'b1;
  assign dram_wr_sel_o = rgn_hit ? nib[WR_EN_BIT] : 1'b1;
endmodule

// File: rtl/shadow_attr_checker.sv
module shadow_attr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [7:0]  cfg_addr_i,
  input logic [7:0]  cfg_wdata_i,
  input logic [7:0]  cfg_rdata_o,
  input logic [31:0] mem_addr_i,
  input logic        dram_rd_sel_o,
  input logic        dram_wr_sel_o
);
  logic in_win, in_f, in_c0, attr_off;
  assign in_win   = (mem_addr_i >= 32'h000C_0000) && (mem_addr_i <= 32'h000F_FFFF);
  assign in_f     = (mem_addr_i >= 32'h000F_0000) && (mem_addr_i <= 32'h000F_FFFF);
  assign in_c0    = (mem_addr_i >= 32'h000C_0000) && (mem_addr_i <= 32'h000C_3FFF);
  assign attr_off = (cfg_addr_i >= 8'h59) && (cfg_addr_i <= 8'h5F);

  // R8
  outside_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (dram_rd_sel_o && dram_wr_sel_o));

  // R2
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && attr_off) ##1 (cfg_addr_i == $past(cfg_addr_i)) |-> cfg_rdata_o == $past(cfg_wdata_i));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i ##1 $stable(cfg_addr_i) |-> $stable(cfg_rdata_o));

  // R4
  bios_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_f && cfg_addr_i == 8'h59) |-> dram_rd_sel_o == cfg_rdata_o[4]);

  // R5
  first_blk_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_c0 && cfg_addr_i == 8'h5A) |-> dram_wr_sel_o == cfg_rdata_o[1]);

  // R2
  other_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attr_off |-> cfg_rdata_o == 8'h00);
endmodule

bind shadow_attr_decoder shadow_attr_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_addr_i    (cfg_addr_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .mem_addr_i    (mem_addr_i),
  .dram_rd_sel_o (dram_rd_sel_o),
  .dram_wr_sel_o (dram_wr_sel_o)
);

// File: tb/shadow_attr_decoder_tb.sv
module shadow_attr_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [31:0] mem_addr = 32'h0;
  logic        rd_sel, wr_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_attr_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .mem_addr_i(mem_addr),
    .dram_rd_sel_o(rd_sel), .dram_wr_sel_o(wr_sel)
  );

  function automatic int exp_region(input logic [31:0] a);
    if (a < 32'hC0000 || a > 32'hFFFFF) return -1;
    if (a >= 32'hF0000) return 1;
    return 2 + int'((a - 32'hC0000) / 32'h4000);
  endfunction

  function automatic logic [1:0] exp_sel(input logic [31:0] a); // {rd,wr}
    int r;
    logic [3:0] n;
    r = exp_region(a);
    if (r < 0) return 2'b11;
    n = (r % 2 == 1) ? model[r/2][7:4] : model[r/2][3:0];
    return {n[0], n[1]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] off);
    if (off >= 8'h59 && off <= 8'h5F) return model[off - 8'h59];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off >= 8'h59 && off <= 8'h5F) model[off - 8'h59] = d;
  endtask

  task automatic cfg_read_chk(input logic [7:0] off, input string req);
    cfg_addr = off;
    #1;
    chk(cfg_rdata == exp_rd(off), req, 32'(cfg_rdata), 32'(exp_rd(off)));
  endtask

  task automatic probe(input logic [31:0] a, input string req);
    logic [1:0] e;
    mem_addr = a;
    #1;
    e = exp_sel(a);
    chk({rd_sel, wr_sel} == e, req, {a[29:0], rd_sel, wr_sel}, {a[29:0], e});
  endtask

  function automatic logic [31:0] rnd_addr();
    int unsigned k;
    k = $urandom_range(0, 9);
    if (k < 7) return 32'hC0000 + ($urandom % 32'h40000);
    if (k == 7) return $urandom % 32'hC0000;
    if (k == 8) return 32'h100000 + ($urandom % 32'h100000);
    return $urandom;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 7; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 7; i++) cfg_read_chk(8'h59 + 8'(i), "R1");
    probe(32'hF0000, "R1");
    probe(32'hC0000, "R1");

    // R2 full byte kept, unused bits included
    cfg_write(8'h5C, 8'hA5);
    cfg_read_chk(8'h5C, "R2");
    cfg_write(8'h58, 8'hFF);
    cfg_read_chk(8'h58, "R2");
    cfg_write(8'h60, 8'hFF);
    cfg_read_chk(8'h60, "R2");
    for (int i = 0; i < 7; i++) cfg_read_chk(8'h59 + 8'(i), "R2");
    probe(32'hDFFFF, "R2");

    // R6 reserved field: low nibble of 0x59 all set, F region still off
    cfg_write(8'h59, 8'h0F);
    probe(32'hF0000, "R6");
    probe(32'hFFFFF, "R6");
    probe(32'hC0000, "R6");
    probe(32'hBFFFF, "R6");

    // R3/R4 odd index uses high nibble: region 1 read-only
    cfg_write(8'h59, 8'h10);
    probe(32'hF8000, "R3");
    probe(32'hFFFFF, "R4");

    // R10 region 2 write-only, region 3 read-only
    cfg_write(8'h5A, 8'h12);
    probe(32'hC0000, "R10");
    probe(32'hC3FFF, "R10");
    probe(32'hC4000, "R10");
    probe(32'hC7FFF, "R3");

    // R5 unused bits 2 and 3 do nothing
    cfg_write(8'h5A, 8'hCC);
    probe(32'hC1000, "R5");
    probe(32'hC5000, "R5");

    // R7 region boundaries, one distinct code per register
    cfg_write(8'h5B, 8'h31);
    cfg_write(8'h5C, 8'h12);
    cfg_write(8'h5D, 8'h23);
    cfg_write(8'h5E, 8'h01);
    cfg_write(8'h5F, 8'h32);
    foreach (model[i]) begin end
    for (int r = 2; r < 14; r++) begin
      logic [31:0] b;
      b = (r < 10) ? 32'hC0000 + 32'(r - 2) * 32'h4000 : 32'hE0000 + 32'(r - 10) * 32'h4000;
      probe(b, "R7");
      probe(b + 32'h3FFF, "R7");
    end

    // R8 outside the window and aliases above 1 MB
    cfg_write(8'h59, 8'h00);
    cfg_write(8'h5A, 8'h00);
    probe(32'hBFFFF, "R8");
    probe(32'h100000, "R8");
    probe(32'h001C0000, "R8");
    probe(32'hFFFFFFFF, "R8");
    probe(32'h000C0000, "R8");

    // R9 new value not seen before the edge, seen after
    mem_addr = 32'hE4000;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h5E; cfg_wdata = 8'h33;
    #1;
    chk({rd_sel, wr_sel} == exp_sel(32'hE4000), "R9", 32'({rd_sel, wr_sel}), 32'(exp_sel(32'hE4000)));
    @(negedge clk);
    cfg_we = 1'b0;
    model[5] = 8'h33;
    #1;
    chk({rd_sel, wr_sel} == 2'b11, "R9", 32'({rd_sel, wr_sel}), 32'h3);

    // random mix
    for (int n = 0; n < 400; n++) begin
      cfg_write(8'(8'h57 + $urandom_range(0, 10)), 8'($urandom));
      for (int m = 0; m < 3; m++) probe(rnd_addr(), "R7");
      cfg_read_chk(8'(8'h57 + $urandom_range(0, 10)), "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule